// File: doc/BRIEF.md
# Memory Background Pattern Test Sequencer

This block is a self-test engine that drives a word-addressed memory through a simple request/acknowledge controller port. After a start pulse it runs up to four background patterns: solid zeros, solid ones, a physical checkerboard and its inverse. For each enabled pattern it first writes every word of the array and then reads every word back. Each read word is compared with the value the pattern expects.

The checkerboard is laid out by where the cells physically sit, not by the logical address. The low address bits select the physical row. The high address bits select a column inside a group of columns, and each data bit lane owns one group. A cell's checkerboard value is the parity of its row index plus its physical column index. The sequencer keeps one record of the first mismatch it finds: the address, the pattern code and the differing bits. It also keeps a sticky fail flag. The array can be run as full-width words or as half-width words. In half-width mode the upper lanes are written as zero and are not compared.

Top module: `mem_pat_top`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and mem_req_o are all low, and no request is issued while the block is idle.
- R2: Patterns run in the fixed order zeros (code 0), ones (code 1), checkerboard (code 2), inverse checkerboard (code 3). Bit n of pat_en_i enables code n, and any pattern whose bit is clear is skipped.
- R3: For each enabled pattern, a write pass covers addresses 0 to 2^ADDR_W-1 in ascending order. A read pass over the same ascending sequence follows it.
- R4: In checkerboard mode, bit lane l at address a is (a[0]) XOR bit 0 of (l*2^(ADDR_W-ROW_W) + a[ADDR_W-1:ROW_W]). In inverse checkerboard mode the value is the complement of that.
- R5: When wide_i is 0 at start, the upper DATA_W/2 lanes are written as 0 and mismatches in those lanes are ignored. When wide_i is 1, all lanes are written and compared.
- R6: Only one request is outstanding at a time. While mem_req_o is high and mem_ack_i is low, the address, the write enable and the write data hold steady. A write or read completes in the cycle mem_ack_i is high, and mem_rdata_i is sampled in that cycle.
- R7: The first mismatch sets fail_o and latches err_addr_o, err_pat_o and err_diff_o, where err_diff_o is expected XOR read data over the compared lanes. Later mismatches in the same run leave the record unchanged.
- R8: done_o is high for exactly one cycle after the last enabled read pass ends. busy_o is low in that cycle.
- R9: A start pulse while busy is ignored. An accepted start clears fail_o and the error record.
- R10: A start with pat_en_i equal to 0 produces a done pulse without issuing any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| pat_en_i | input | 4 | Pattern enable mask, bit n enables pattern code n |
| wide_i | input | 1 | 1 = full-width words, 0 = half-width words |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Controller completion handshake |
| mem_rdata_i | input | DATA_W | Read data, valid when mem_ack_i is high on a read |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| err_addr_o | output | ADDR_W | Address of the first mismatch |
| err_pat_o | output | 2 | Pattern code of the first mismatch |
| err_diff_o | output | DATA_W | Differing bits of the first mismatch |

## Verification
Two events can land on the same clock edge: the compare of the final read, and the step from the last pattern toward the done pulse. The bench provokes this by forcing a stuck-at-0 bit at the highest address while only the ones pattern is enabled. It then checks that the done pulse still arrives and that fail_o and the error record show that last address. A second case places a start request inside a run that is already going. The bench judges it by the order of accepted transactions, which must still follow the original mask and width.

// File: rtl/mem_pat_pkg.sv
package mem_pat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_WR, ST_RD, ST_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    PAT_ZERO = 2'd0,
    PAT_ONE  = 2'd1,
    PAT_CHK  = 2'd2,
    PAT_CHKB = 2'd3
  } pat_e;

  localparam int unsigned NUM_PAT = 4;
endpackage

// File: rtl/mem_pat_gen.sv
module mem_pat_gen
  import mem_pat_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  pat_e              pat_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] word_o,
  output logic [DATA_W-1:0] lane_mask_o
);
  localparam int unsigned COL_W = ADDR_W - ROW_W;
  localparam int unsigned GROUP = 1 << COL_W;
  localparam int unsigned HALF  = DATA_W / 2;

  logic row_lsb, sel_lsb;
  assign row_lsb = addr_i[0];
  assign sel_lsb = addr_i[ROW_W];

  for (genvar l = 0; l < DATA_W; l++) begin : g_lane
    // physical column = l*GROUP + column-in-group
    localparam logic LANE_ODD = logic'((l * GROUP) % 2);
    logic chk, bit_v;
    assign chk = row_lsb ^ sel_lsb ^ LANE_ODD;
    always_comb begin
      unique case (pat_i)
        PAT_ZERO: bit_v = 1'b0;
        PAT_ONE:  bit_v = 1'b1;
        PAT_CHK:  bit_v = chk;
        default:  bit_v = ~chk;
      endcase
    end
    if (l < HALF) begin : g_low
      assign lane_mask_o[l] = 1'b1;
    end else begin : g_high
      assign lane_mask_o[l] = wide_i;
    end
    assign word_o[l] = bit_v & lane_mask_o[l];
  end
endmodule

// File: rtl/mem_pat_seq.sv
module mem_pat_seq
  import mem_pat_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_PAT-1:0] pat_en_i,
  input  logic              wide_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output pat_e              pat_o,
  output logic              wide_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cmp_en_o,
  output logic              clr_o
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam int unsigned PI_W = $clog2(NUM_PAT) + 1;

  seq_st_e            st_q;
  logic [NUM_PAT-1:0] mask_q;
  logic               wide_q;
  logic [PI_W-1:0]    pi_q;
  logic [ADDR_W-1:0]  addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      wide_q <= 1'b0;
      pi_q   <= '0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mask_q <= pat_en_i;
          wide_q <= wide_i;
          pi_q   <= '0;
          addr_q <= '0;
          st_q   <= ST_PICK;
        end
        ST_PICK: begin
          if (pi_q[PI_W-1]) st_q <= ST_DONE;
          else if (mask_q[pi_q[PI_W-2:0]]) begin
            addr_q <= '0;
            st_q   <= ST_WR;
          end else pi_q <= pi_q + 1'b1;
        end
        ST_WR: if (ack_i) begin
          if (addr_q == LAST) begin
            addr_q <= '0;
            st_q   <= ST_RD;
          end else addr_q <= addr_q + 1'b1;
        end
        ST_RD: if (ack_i) begin
          if (addr_q == LAST) begin
            addr_q <= '0;
            pi_q   <= pi_q + 1'b1;
            st_q   <= ST_PICK;
          end else addr_q <= addr_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o    = (st_q == ST_WR) || (st_q == ST_RD);
  assign we_o     = (st_q == ST_WR);
  assign addr_o   = addr_q;
  assign pat_o    = pat_e'(pi_q[PI_W-2:0]);
  assign wide_o   = wide_q;
  assign busy_o   = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o   = (st_q == ST_DONE);
  assign cmp_en_o = (st_q == ST_RD) && ack_i;
  assign clr_o    = (st_q == ST_IDLE) && start_i;
endmodule

// File: rtl/mem_pat_cmp.sv
module mem_pat_cmp
  import mem_pat_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cmp_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  pat_e              pat_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] lane_mask_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [1:0]        err_pat_o,
  output logic [DATA_W-1:0] err_diff_o
);
  logic [DATA_W-1:0] diff;
  assign diff = (exp_i ^ rdata_i) & lane_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o     <= 1'b0;
      err_addr_o <= '0;
      err_pat_o  <= '0;
      err_diff_o <= '0;
    end else if (clr_i) begin
      fail_o     <= 1'b0;
      err_addr_o <= '0;
      err_pat_o  <= '0;
      err_diff_o <= '0;
    end else if (cmp_en_i && (diff != '0) && !fail_o) begin
      fail_o     <= 1'b1;
      err_addr_o <= addr_i;
      err_pat_o  <= pat_i;
      err_diff_o <= diff;
    end
  end
endmodule

// File: rtl/mem_pat_top.sv
module mem_pat_top
  import mem_pat_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        pat_en_i,
  input  logic              wide_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [1:0]        err_pat_o,
  output logic [DATA_W-1:0] err_diff_o
);
  pat_e              cur_pat;
  logic              wide_q, cmp_en, clr;
  logic [DATA_W-1:0] exp_word, lane_mask;

  mem_pat_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .pat_en_i (pat_en_i),
    .wide_i   (wide_i),
    .ack_i    (mem_ack_i),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .pat_o    (cur_pat),
    .wide_o   (wide_q),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .cmp_en_o (cmp_en),
    .clr_o    (clr)
  );

  mem_pat_gen #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) i_gen (
    .pat_i       (cur_pat),
    .addr_i      (mem_addr_o),
    .wide_i      (wide_q),
    .word_o      (exp_word),
    .lane_mask_o (lane_mask)
  );

  assign mem_wdata_o = exp_word;

  mem_pat_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .cmp_en_i    (cmp_en),
    .addr_i      (mem_addr_o),
    .pat_i       (cur_pat),
    .exp_i       (exp_word),
    .lane_mask_i (lane_mask),
    .rdata_i     (mem_rdata_i),
    .fail_o      (fail_o),
    .err_addr_o  (err_addr_o),
    .err_pat_o   (err_pat_o),
    .err_diff_o  (err_diff_o)
  );
endmodule

// File: rtl/mem_pat_chk.sv
module mem_pat_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] err_addr_o,
  input logic [1:0]        err_pat_o,
  input logic [DATA_W-1:0] err_diff_o,
  input logic              wide_q
);
  p_idle_noreq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !wide_q) |-> (mem_wdata_o[DATA_W-1:DATA_W/2] == '0));

  p_fail_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && busy_o) |=> (fail_o && $stable(err_addr_o)
      && $stable(err_pat_o) && $stable(err_diff_o)));

  p_diff_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (err_diff_o != '0));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind mem_pat_top mem_pat_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .err_addr_o  (err_addr_o),
  .err_pat_o   (err_pat_o),
  .err_diff_o  (err_diff_o),
  .wide_q      (wide_q)
);

// File: tb/test_mem_pat_top.sv
`timescale 1ns/1ps
module test_mem_pat_top;
  localparam int AW = 6;
  localparam int RW = 3;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    pat_en = '0;
  logic          wide = 1'b1;
  logic          req, we, ack, busy, done, fail;
  logic [AW-1:0] addr, err_addr;
  logic [DW-1:0] wdata, rdata, err_diff;
  logic [1:0]    err_pat;

  always #5 clk = ~clk;

  mem_pat_top #(.ADDR_W(AW), .ROW_W(RW), .DATA_W(DW)) i_mem_pat_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pat_en_i(pat_en), .wide_i(wide),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .fail_o(fail), .err_addr_o(err_addr), .err_pat_o(err_pat), .err_diff_o(err_diff)
  );

  int n_checks = 0;
  int n_errs = 0;

  task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // expected pattern word from the requirement formulas (R4, R5)
  function automatic logic [DW-1:0] exp_word(input int p, input int a, input bit w);
    logic [DW-1:0] r;
    for (int l = 0; l < DW; l++) begin
      int row = a % (1 << RW);
      int col = l * (1 << (AW - RW)) + (a >> RW);
      bit cb = bit'((row ^ col) & 1);
      bit b = (p == 0) ? 1'b0 : (p == 1) ? 1'b1 : (p == 2) ? cb : !cb;
      if (!w && l >= DW / 2) b = 1'b0;
      r[l] = b;
    end
    return r;
  endfunction

  // memory model with one optional stuck bit on reads
  logic [DW-1:0] mem [NW];
  bit   f_en = 0;
  int   f_addr = 0, f_bit = 0;
  bit   f_val = 0;
  logic ack_q;
  logic [DW-1:0] rdata_q;
  assign ack = ack_q;
  assign rdata = rdata_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      rdata_q <= '0;
    end else if (req && !ack_q) begin
      ack_q <= 1'b1;
      if (we) mem[addr] <= wdata;
      else begin
        logic [DW-1:0] v;
        v = mem[addr];
        if (f_en && int'(addr) == f_addr) v[f_bit] = f_val;
        rdata_q <= v;
      end
    end else ack_q <= 1'b0;
  end

  // transaction order monitor (R2, R3, R4, R5)
  int m_pat = 4, m_addr = 0, m_err = 0, m_txn = 0;
  bit m_rd = 0, m_wide = 1;
  logic [3:0] m_mask = '0;

  function automatic int next_pat(input int from, input logic [3:0] mk);
    for (int p = from; p < 4; p++) if (mk[p]) return p;
    return 4;
  endfunction

  always @(posedge clk) begin
    if (rst_n && req && ack) begin
      m_txn++;
      if (m_pat > 3 || we !== !m_rd || int'(addr) != m_addr) m_err++;
      else if (we && wdata !== exp_word(m_pat, m_addr, m_wide)) m_err++;
      if (m_addr == NW - 1) begin
        m_addr = 0;
        if (!m_rd) m_rd = 1;
        else begin m_rd = 0; m_pat = next_pat(m_pat + 1, m_mask); end
      end else m_addr++;
    end
  end

  task automatic run(input logic [3:0] mk, input bit w);
    @(negedge clk);
    m_mask = mk; m_wide = w; m_addr = 0; m_rd = 0; m_err = 0; m_txn = 0;
    m_pat = next_pat(0, mk);
    pat_en = mk; wide = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  function automatic int first_fail_pat(input logic [3:0] mk, input int a, input int b,
                                        input bit v, input bit w);
    for (int p = 0; p < 4; p++) begin
      logic [DW-1:0] e;
      if (!mk[p]) continue;
      e = exp_word(p, a, w);
      if (!w && b >= DW / 2) continue;
      if (e[b] != v) return p;
    end
    return -1;
  endfunction

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 fail", fail, 0);
    check("R1 req", req, 0);
  endtask

  task automatic t_clean_all();
    bit got;
    f_en = 0;
    run(4'b1111, 1'b1);
    check("R1 busy after start", busy, 1);
    wait_done(got);
    check("R8 done seen", got, 1);
    check("R8 busy low at done", busy, 0);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R2 R3 R4 order and data", m_err, 0);
    check("R3 transaction count", m_txn, 8 * NW);
    check("R2 all patterns ran", m_pat, 4);
    check("R7 no fail", fail, 0);
  endtask

  task automatic t_subset();
    bit got;
    f_en = 0;
    run(4'b0110, 1'b1);
    wait_done(got);
    check("R2 subset done", got, 1);
    check("R2 subset order", m_err, 0);
    check("R2 subset count", m_txn, 4 * NW);
  endtask

  task automatic t_narrow();
    bit got;
    f_en = 1; f_addr = 5; f_bit = 12; f_val = 1;
    run(4'b1111, 1'b0);
    wait_done(got);
    check("R5 narrow data", m_err, 0);
    check("R5 upper lane fault ignored", fail, 0);
    f_en = 0;
  endtask

  task automatic t_first_fault();
    bit got;
    f_en = 1; f_addr = 37; f_bit = 3; f_val = 1;
    run(4'b1111, 1'b1);
    wait_done(got);
    check("R7 fail set", fail, 1);
    check("R7 first addr", err_addr, 37);
    check("R7 first pattern kept", err_pat, first_fail_pat(4'b1111, 37, 3, 1, 1));
    check("R7 diff", err_diff, 16'h0008);
    f_en = 0;
  endtask

  task automatic t_chk_fault();
    bit got;
    f_en = 1; f_addr = 21; f_bit = 5; f_val = 0;
    run(4'b1100, 1'b1);
    wait_done(got);
    check("R4 chk fault fail", fail, 1);
    check("R4 chk fault pattern", err_pat, first_fail_pat(4'b1100, 21, 5, 0, 1));
    check("R4 chk fault addr", err_addr, 21);
    f_en = 0;
  endtask

  task automatic t_last_addr();
    bit got;
    f_en = 1; f_addr = NW - 1; f_bit = 0; f_val = 0;
    run(4'b0010, 1'b1);
    check("R9 start clears fail", fail, 0);
    wait_done(got);
    check("R8 done with last-read fault", got, 1);
    check("R7 last addr fail", fail, 1);
    check("R7 last addr", err_addr, NW - 1);
    check("R7 last addr pattern", err_pat, 1);
    f_en = 0;
  endtask

  task automatic t_start_busy();
    bit got;
    run(4'b1001, 1'b1);
    repeat (20) @(negedge clk);
    pat_en = 4'b0010; wide = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    check("R9 restart ignored order", m_err, 0);
    check("R9 restart ignored count", m_txn, 4 * NW);
  endtask

  task automatic t_empty();
    bit got;
    run(4'b0000, 1'b1);
    wait_done(got);
    check("R10 done with empty mask", got, 1);
    check("R10 no requests", m_txn, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_all();
    t_subset();
    t_narrow();
    t_first_fault();
    t_chk_fault();
    t_last_addr();
    t_start_busy();
    t_empty();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule